// File: doc/BRIEF.md
# Serial Slot Address Shifter

This block sends a small controller address, one bit at a time, down a daisy chain of controller slots. Each bit goes out on a serial data line with a matching one-cycle shift-clock pulse. The address is sent in inverted form, least-significant bit first. A single address transfer is started with a one-cycle strobe, and a one-cycle completion pulse follows the last bit.

A sweep mode assigns an address to every slot of the chain. One strobe starts a run of back-to-back transfers. The addresses count down from the highest slot number to zero, and a separate pulse marks the end of the run. While a transfer or a sweep is in progress, further strobes are ignored. The address currently on the line is reported, so that a surrounding controller can follow the sweep.

Top module: `nas_addr_shifter`

## Requirements
- R1: The bits shifted out for an address A are A XOR 4'b1111 (all bits inverted).
- R2: Bits leave least-significant first: the first pulse carries bit 0 of the inverted value and the fourth pulse carries bit 3.
- R3: Each transfer produces exactly four `ser_clk` pulses. Each pulse is high for one cycle and is followed by at least one low cycle.
- R4: `ser_data` holds the same value in the cycle before each `ser_clk` pulse and during the pulse.
- R5: `done` is high for exactly one cycle. That cycle follows the fourth pulse and is the 9th cycle after the edge that accepted the strobe (setup in cycle 1, pulses in cycles 2, 4, 6 and 8).
- R6: A `start` or `sweep_start` that arrives while `busy` is high is ignored. `busy` is low in the `done` cycle of a single transfer, and a strobe in that cycle is accepted.
- R7: A synchronous reset returns the block to idle. From the first cycle after reset `ser_clk`, `ser_data`, `busy`, `done` and `sweep_done` are low.
- R8: A sweep runs 16 transfers carrying addresses 15, 14, … 0 in that order. Each transfer begins in the cycle after the previous `done`, so `done` recurs every 9 cycles. `slot_addr` shows the address being sent.
- R9: `sweep_done` pulses together with the final `done` of a sweep. `busy` stays high through every earlier `done` cycle of the sweep. When `sweep_start` and `start` arrive together, the sweep wins.
- R10: Whenever `busy` is low, `ser_clk` and `ser_data` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Strobe: send `addr_in` once |
| addr_in | input | 4 | Address for a single transfer |
| sweep_start | input | 1 | Strobe: send every slot address, counting down |
| ser_clk | output | 1 | Shift-clock pulse, one per bit |
| ser_data | output | 1 | Serial address bit |
| busy | output | 1 | Transfer or sweep in progress |
| done | output | 1 | One-cycle pulse at the end of each transfer |
| sweep_done | output | 1 | One-cycle pulse at the end of a sweep |
| slot_addr | output | 4 | Address of the current or most recent transfer |

## Verification
A wrong bit index or an off-by-one in the phase sequence shows up at the ports within one transfer: a fifth pulse, a missing pulse, or `done` away from cycle 9. A wrong inversion mask or shift direction turns the decoded address into the wrong value on the first transfer that carries an asymmetric address. A slot counter that skips a value or stops early shows as a wrong decoded address, or as `sweep_done` on the wrong transfer. A leaking accept path shows as extra pulses in the quiet cycles after an ignored strobe.

// File: rtl/nas_pkg.sv
package nas_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SETUP = 2'd1,
      PH_PULSE = 2'd2,
      PH_DONE  = 2'd3
   } nas_phase_t;
endpackage

// File: rtl/nas_bit_path.sv
module nas_bit_path #(
   parameter int ADDR_W    = 4,
   parameter bit INVERT    = 1'b1,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic [ADDR_W-1:0] raw_addr,
   input  logic [ADDR_W-1:0] work,
   output logic [ADDR_W-1:0] load_val,
   output logic [ADDR_W-1:0] next_val,
   output logic              cur_bit
);
   localparam logic [ADDR_W-1:0] FLIP_MASK = {ADDR_W{1'b1}};

   generate
      if (INVERT) begin : g_inv
         assign load_val = raw_addr ^ FLIP_MASK;
      end else begin : g_pass
         assign load_val = raw_addr;
      end

      if (LSB_FIRST) begin : g_lsb
         assign next_val = work >> 1;
         assign cur_bit  = work[0];
      end else begin : g_msb
         assign next_val = work << 1;
         assign cur_bit  = work[ADDR_W-1];
      end
   endgenerate
endmodule

// File: rtl/nas_shift_engine.sv
module nas_shift_engine
   import nas_pkg::*;
#(
   parameter int ADDR_W    = 4,
   parameter bit INVERT    = 1'b1,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              launch,
   input  logic [ADDR_W-1:0] launch_addr,
   output logic              ser_clk,
   output logic              ser_data,
   output logic              eng_busy,
   output logic              eng_done
);
   localparam int CNT_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1;
   localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ADDR_W - 1);

   nas_phase_t        phase;
   logic [ADDR_W-1:0] work;
   logic [CNT_W-1:0]  bit_idx;
   logic [ADDR_W-1:0] load_val;
   logic [ADDR_W-1:0] next_val;
   logic              cur_bit;

   nas_bit_path #(
      .ADDR_W   (ADDR_W),
      .INVERT   (INVERT),
      .LSB_FIRST(LSB_FIRST)
   ) path_i (
      .raw_addr(launch_addr),
      .work    (work),
      .load_val(load_val),
      .next_val(next_val),
      .cur_bit (cur_bit)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         phase   <= PH_IDLE;
         work    <= '0;
         bit_idx <= '0;
      end else begin
         case (phase)
            PH_IDLE, PH_DONE: begin
               if (launch) begin
                  phase   <= PH_SETUP;
                  work    <= load_val;
                  bit_idx <= '0;
               end else begin
                  phase <= PH_IDLE;
               end
            end
            PH_SETUP: phase <= PH_PULSE;
            PH_PULSE: begin
               if (bit_idx == LAST_IDX) begin
                  phase <= PH_DONE;
               end else begin
                  phase   <= PH_SETUP;
                  bit_idx <= bit_idx + 1'b1;
                  work    <= next_val;
               end
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   always_comb begin
      eng_busy = (phase == PH_SETUP) || (phase == PH_PULSE);
      ser_clk  = (phase == PH_PULSE);
      ser_data = eng_busy && cur_bit;
      eng_done = (phase == PH_DONE);
   end
endmodule

// File: rtl/nas_sweep_seq.sv
module nas_sweep_seq #(
   parameter int ADDR_W   = 4,
   parameter int SLOT_CNT = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sweep_go,
   input  logic              eng_done,
   output logic              seq_active,
   output logic              cont_launch,
   output logic              last_done,
   output logic [ADDR_W-1:0] next_slot
);
   localparam logic [ADDR_W-1:0] TOP_SLOT = ADDR_W'(SLOT_CNT - 1);

   logic [ADDR_W-1:0] slot;

   always_ff @(posedge clk) begin
      if (rst) begin
         seq_active <= 1'b0;
         slot       <= '0;
      end else if (sweep_go) begin
         seq_active <= 1'b1;
         slot       <= TOP_SLOT;
      end else if (seq_active && eng_done) begin
         if (slot == '0) begin
            seq_active <= 1'b0;
         end else begin
            slot <= slot - 1'b1;
         end
      end
   end

   always_comb begin
      cont_launch = seq_active && eng_done && (slot != '0);
      last_done   = seq_active && eng_done && (slot == '0);
      next_slot   = slot - 1'b1;
   end
endmodule

// File: rtl/nas_addr_shifter.sv
module nas_addr_shifter #(
   parameter int ADDR_W    = 4,
   parameter int SLOT_CNT  = 16,
   parameter bit INVERT    = 1'b1,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              sweep_start,
   output logic              ser_clk,
   output logic              ser_data,
   output logic              busy,
   output logic              done,
   output logic              sweep_done,
   output logic [ADDR_W-1:0] slot_addr
);
   localparam logic [ADDR_W-1:0] TOP_SLOT = ADDR_W'(SLOT_CNT - 1);

   generate
      if (ADDR_W < 1) begin : g_bad_width
         $error("ADDR_W must be at least 1");
      end
      if (SLOT_CNT < 2 || SLOT_CNT > (1 << ADDR_W)) begin : g_bad_slots
         $error("SLOT_CNT must lie in 2 .. 2**ADDR_W");
      end
   endgenerate

   logic              eng_busy;
   logic              eng_done;
   logic              seq_active;
   logic              cont_launch;
   logic              last_done;
   logic [ADDR_W-1:0] next_slot;
   logic              sweep_go;
   logic              shot_go;
   logic              launch;
   logic [ADDR_W-1:0] launch_addr;

   always_comb begin
      busy        = eng_busy || (seq_active && !last_done);
      sweep_go    = sweep_start && !busy;
      shot_go     = start && !sweep_start && !busy;
      launch      = sweep_go || shot_go || cont_launch;
      if (sweep_go)         launch_addr = TOP_SLOT;
      else if (cont_launch) launch_addr = next_slot;
      else                  launch_addr = addr_in;
      done        = eng_done;
      sweep_done  = last_done;
   end

   always_ff @(posedge clk) begin
      if (rst)         slot_addr <= '0;
      else if (launch) slot_addr <= launch_addr;
   end

   nas_shift_engine #(
      .ADDR_W   (ADDR_W),
      .INVERT   (INVERT),
      .LSB_FIRST(LSB_FIRST)
   ) engine_i (
      .clk        (clk),
      .rst        (rst),
      .launch     (launch),
      .launch_addr(launch_addr),
      .ser_clk    (ser_clk),
      .ser_data   (ser_data),
      .eng_busy   (eng_busy),
      .eng_done   (eng_done)
   );

   nas_sweep_seq #(
      .ADDR_W  (ADDR_W),
      .SLOT_CNT(SLOT_CNT)
   ) seq_i (
      .clk        (clk),
      .rst        (rst),
      .sweep_go   (sweep_go),
      .eng_done   (eng_done),
      .seq_active (seq_active),
      .cont_launch(cont_launch),
      .last_done  (last_done),
      .next_slot  (next_slot)
   );
endmodule

// File: rtl/nas_addr_shifter_chk.sv
module nas_addr_shifter_chk #(
   parameter int ADDR_W = 4
) (
   input logic clk,
   input logic rst,
   input logic ser_clk,
   input logic ser_data,
   input logic busy,
   input logic done,
   input logic sweep_done
);
   localparam int PC_W = $clog2(ADDR_W + 2) + 1;

   logic [PC_W-1:0] pulse_cnt;

   always_ff @(posedge clk) begin
      if (rst)          pulse_cnt <= '0;
      else if (done)    pulse_cnt <= '0;
      else if (ser_clk) pulse_cnt <= pulse_cnt + 1'b1;
   end

   a_r3_clk_single: assert property (@(posedge clk) disable iff (rst)
      ser_clk |=> !ser_clk);

   a_r3_four_pulses: assert property (@(posedge clk) disable iff (rst)
      done |-> (pulse_cnt == PC_W'(ADDR_W)));

   a_r4_data_held: assert property (@(posedge clk) disable iff (rst)
      ser_clk |-> (ser_data == $past(ser_data)) && $past(busy));

   a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   a_r5_done_after_pulse: assert property (@(posedge clk) disable iff (rst)
      done |-> $past(ser_clk));

   a_r9_sweep_with_done: assert property (@(posedge clk) disable iff (rst)
      sweep_done |-> done && !busy);

   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !busy |-> !ser_clk && !ser_data);
endmodule

bind nas_addr_shifter nas_addr_shifter_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk       (clk),
   .rst       (rst),
   .ser_clk   (ser_clk),
   .ser_data  (ser_data),
   .busy      (busy),
   .done      (done),
   .sweep_done(sweep_done)
);

// File: tb/nas_addr_shifter_tb_top.sv
`timescale 1ns/1ps
module nas_addr_shifter_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0;
   logic [3:0] addr_in = 4'd0;
   logic       sweep_start = 1'b0;
   logic       ser_clk, ser_data, busy, done, sweep_done;
   logic [3:0] slot_addr;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   nas_addr_shifter dut_i (
      .clk(clk), .rst(rst), .start(start), .addr_in(addr_in),
      .sweep_start(sweep_start), .ser_clk(ser_clk), .ser_data(ser_data),
      .busy(busy), .done(done), .sweep_done(sweep_done), .slot_addr(slot_addr)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Follows one transfer from the cycle after the accepting edge.
   task automatic capture(input int inj_cyc, input logic [3:0] inj_addr,
                          output logic [3:0] got, output int npulse,
                          output int done_cyc, output bit setup_ok,
                          output bit busy_at_done, output bit sdone_at_done,
                          output logic [3:0] slot_at_done);
      logic prev_clk = 1'b0;
      logic prev_dat = 1'b0;
      got = 4'd0; npulse = 0; done_cyc = -1; setup_ok = 1'b1;
      busy_at_done = 1'b0; sdone_at_done = 1'b0; slot_at_done = 4'd0;
      for (int c = 1; c <= 40 && done_cyc < 0; c++) begin
         @(negedge clk);
         sweep_start = 1'b0;
         if (c == inj_cyc) begin
            start = 1'b1; addr_in = inj_addr;
         end else begin
            start = 1'b0;
         end
         if (ser_clk) begin
            if (prev_clk || (prev_dat !== ser_data)) setup_ok = 1'b0;
            if (npulse < 4) got[npulse] = ser_data;
            npulse++;
         end
         if (done) begin
            done_cyc = c; busy_at_done = busy;
            sdone_at_done = sweep_done; slot_at_done = slot_addr;
         end
         prev_clk = ser_clk; prev_dat = ser_data;
      end
   endtask

   task automatic quiet_window(input string req, input int ncyc);
      int act = 0;
      for (int c = 0; c < ncyc; c++) begin
         @(negedge clk);
         start = 1'b0;
         if (ser_clk || ser_data || done || busy) act++;
      end
      chk(act == 0, req, "activity in quiet window", act, 0);
   endtask

   task automatic t_reset_state();
      @(negedge clk);
      chk({ser_clk, ser_data, busy, done, sweep_done} == 5'b0, "R7",
          "outputs in reset", {ser_clk, ser_data, busy, done, sweep_done}, 0);
      rst = 1'b0;
      @(negedge clk);
      chk({ser_clk, ser_data, busy, done, sweep_done} == 5'b0, "R7",
          "outputs after reset", {ser_clk, ser_data, busy, done, sweep_done}, 0);
      chk(slot_addr == 4'd0, "R7", "slot_addr after reset", slot_addr, 0);
   endtask

   task automatic t_single(input logic [3:0] a);
      logic [3:0] got, sl; int np, dc; bit su, bd, sd;
      start = 1'b1; addr_in = a;
      capture(0, 4'd0, got, np, dc, su, bd, sd, sl);
      chk(got == (a ^ 4'hF), "R1", $sformatf("inverted value of %0d", a), got, a ^ 4'hF);
      chk(np == 4, "R3", "pulse count", np, 4);
      chk(su, "R4", "data stable before and during pulse", su, 1);
      chk(dc == 9, "R5", "done cycle", dc, 9);
      chk(!bd, "R6", "busy low in done cycle", bd, 0);
      chk(sl == a, "R8", "slot_addr of single transfer", sl, a);
      @(negedge clk);
      chk(!done, "R5", "done width", done, 0);
   endtask

   task automatic t_order();
      logic [3:0] got, sl; int np, dc; bit su, bd, sd;
      // address 4'b1110 is sent as 0001: only the first pulse carries a 1
      start = 1'b1; addr_in = 4'b1110;
      capture(0, 4'd0, got, np, dc, su, bd, sd, sl);
      chk(got[0] == 1'b1 && got[3:1] == 3'b000, "R2", "LSB-first order", got, 1);
   endtask

   task automatic t_ignore_busy();
      logic [3:0] got, sl; int np, dc; bit su, bd, sd;
      start = 1'b1; addr_in = 4'd3;
      capture(3, 4'd12, got, np, dc, su, bd, sd, sl);
      chk(got == 4'hC, "R6", "value unchanged by busy strobe", got, 12);
      chk(np == 4, "R6", "pulses with ignored strobe", np, 4);
      chk(sl == 4'd3, "R6", "slot_addr unchanged", sl, 3);
      quiet_window("R6", 12);
      sweep_start = 1'b1;
      start = 1'b1; addr_in = 4'd5;
      @(negedge clk);
      sweep_start = 1'b0; start = 1'b0;
   endtask

   task automatic t_back_to_back();
      logic [3:0] got, sl; int np, dc; bit su, bd, sd;
      start = 1'b1; addr_in = 4'd9;
      capture(9, 4'd6, got, np, dc, su, bd, sd, sl);
      chk(dc == 9, "R6", "first done cycle", dc, 9);
      capture(0, 4'd0, got, np, dc, su, bd, sd, sl);
      chk(dc == 9, "R6", "strobe in done cycle accepted", dc, 9);
      chk(got == (4'd6 ^ 4'hF), "R6", "second value", got, 4'd6 ^ 4'hF);
   endtask

   task automatic t_sweep();
      logic [3:0] got, sl; int np, dc; bit su, bd, sd;
      int bad_addr = 0, bad_cyc = 0, bad_busy = 0, bad_sd = 0;
      sweep_start = 1'b1;
      start = 1'b1; addr_in = 4'd2;        // R9: sweep wins over start
      for (int k = 0; k < 16; k++) begin
         capture(0, 4'd0, got, np, dc, su, bd, sd, sl);
         if ((got ^ 4'hF) != 4'(15 - k) || sl != 4'(15 - k)) begin
            bad_addr++;
            $display("FAIL R8 slot %0d: actual %0d expected %0d", k, got ^ 4'hF, 15 - k);
         end
         if (dc != 9 || np != 4) bad_cyc++;
         if (k < 15 && (!bd || sd)) bad_busy++;
         if (k == 15 && (bd || !sd)) bad_sd++;
      end
      chk(bad_addr == 0, "R8", "addresses 15 down to 0", bad_addr, 0);
      chk(bad_cyc == 0, "R8", "9-cycle spacing", bad_cyc, 0);
      chk(bad_busy == 0, "R9", "busy held inside sweep", bad_busy, 0);
      chk(bad_sd == 0, "R9", "sweep_done on final done", bad_sd, 0);
      quiet_window("R9", 12);
   endtask

   task automatic t_reset_mid();
      start = 1'b1; addr_in = 4'd0;
      @(negedge clk); start = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      chk({ser_clk, ser_data, busy, done} == 4'b0, "R7", "outputs after mid reset",
          {ser_clk, ser_data, busy, done}, 0);
      rst = 1'b0;
      quiet_window("R7", 12);
   endtask

   initial begin
      t_reset_state();
      t_single(4'd0);
      t_single(4'hF);
      t_single(4'd5);
      t_single(4'hA);
      t_single(4'd3);
      t_order();
      t_ignore_busy();
      // drain the sweep that t_ignore_busy started, then verify it separately
      wait (!busy);
      repeat (3) @(negedge clk);
      t_back_to_back();
      repeat (2) @(negedge clk);
      t_sweep();
      t_reset_mid();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule